// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block is the front end that turns interrupt events into memory stores. It keeps a level register that follows up to 20 level-sensitive source inputs. When an event fires for a source, the block builds a 64-bit trigger word. That word combines a programmable vector offset, the source number and a "state already checked" flag. The block sends it as one store to a programmable notification address.

Software sets the block up through 8-byte register accesses at fixed byte offsets:

- a control word, whose store-EOI bit is brought out as a pin,
- an interrupt-control word, which holds the method bit and the downstream-reset bit,
- an event-buffer base word, which holds a valid bit and a page-size bit,
- the notification port word, whose least significant bit gates issue,
- the vector offset word.

Triggers wait in a small in-order queue while the store port is busy. The store port is a request/acknowledge interface that reports an error per store.

Top module: `ntfy_trigger_gen`

## Requirements
- R1: After reset there is no store request, `trig_ready` is 1, all pulses are 0, `store_eoi` and `esb_map_en` are 0, and every register reads 0.
- R2: The registers at byte offsets 0x20 (control), 0x58 (interrupt control), 0x60 (event-buffer base), 0x68 (notification) and 0x70 (vector offset) read back the last written 64-bit value. Offset 0x28 always reads 0 and ignores writes.
- R3: A read of an unimplemented offset (for example 0x80), or of any offset not a multiple of 8, returns all ones. A write to such an offset changes no register.
- R4: The register at 0x78 is read-only. In big-endian numbering its bit n follows `src_level[n]`, so in LSB-0 numbering source n sits at data bit 63-n. It takes a new input value one cycle after the input changes, while the method bit is clear.
- R5: While interrupt-control data bit 63 (the method bit) is 1, changes on `src_level` leave the level register unchanged. Each change makes `unsup_pulse` high for exactly one cycle.
- R6: A write to 0x58 with data bit 62 set makes `src_reset` high for exactly one cycle after the write.
- R7: The store data has the vector offset (bits 63:32 of register 0x70) in bits 31:0, ORed with the source number. Bit 63 of the store data is set when `trig_checked` was 1. The store address is the notification register with bit 0 cleared.
- R8: A trigger accepted while notification bit 0 is 0 is dropped and no store is made.
- R9: Triggers are stored in arrival order. Up to QDEPTH triggers wait in the queue while one store is outstanding, and `trig_ready` is 0 when the queue is full. `st_req`, `st_addr` and `st_data` hold steady until `st_ack`.
- R10: `store_fail` is high for one cycle after a store is acknowledged with `st_err` = 1, and stays low otherwise.
- R11: In the event-buffer base register, bit 0 is valid and bit 62 selects 64 KiB pages; `esb_base` is the register with both of those bits cleared. `esb_map_on` or `esb_map_off` pulses for one cycle only when a write changes the valid bit, and a write that keeps the valid bit the same pulses neither.
- R12: `store_eoi` equals control register data bit 51 (bit 12 in big-endian numbering).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the access |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for `acc_addr` (combinational) |
| src_level | input | NSRC | Level of each interrupt source |
| trig_valid | input | 1 | Trigger request from the event-state logic |
| trig_src | input | SRC_W | Source number of the trigger |
| trig_checked | input | 1 | Source state was already checked |
| trig_ready | output | 1 | Trigger can be accepted this cycle |
| st_req | output | 1 | Store request |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data (trigger word) |
| st_ack | input | 1 | Store completed |
| st_err | input | 1 | Completed store failed |
| store_fail | output | 1 | One-cycle pulse after a failed store |
| unsup_pulse | output | 1 | Level change ignored under method bit |
| src_reset | output | 1 | One-cycle reset pulse to downstream source state |
| store_eoi | output | 1 | Store-EOI mode enable |
| esb_map_en | output | 1 | Event-buffer window valid |
| esb_page64k | output | 1 | Event-buffer page size is 64 KiB |
| esb_base | output | 64 | Event-buffer base address |
| esb_map_on | output | 1 | Pulse when the window becomes valid |
| esb_map_off | output | 1 | Pulse when the window becomes invalid |

## Verification
The bench targets the bit-numbering traps. A level register that puts source n at LSB bit n, or a store-EOI or page-size decode that takes the wrong bit, returns visibly wrong read data or pin values. It also probes address decoding with a misaligned write next to the control register: a decode that ignores the low address bits overwrites the control word. On the store side, it fills the queue with the port stalled and then drains it. A queue that drops, reorders or overruns entries gives wrong trigger words or the wrong `trig_ready`. It also writes a cleared notification valid bit and checks that a design issuing anyway raises `st_req`. Rewriting the event-buffer base with an unchanged valid bit catches a design that remaps on every write.

// File: rtl/ntfy_pkg.sv
package ntfy_pkg;
    localparam int REG_W = 64;

    localparam logic [7:0] OFF_CTRL  = 8'h20;
    localparam logic [7:0] OFF_EMASK = 8'h28;
    localparam logic [7:0] OFF_ICTL  = 8'h58;
    localparam logic [7:0] OFF_ESB   = 8'h60;
    localparam logic [7:0] OFF_NOTIF = 8'h68;
    localparam logic [7:0] OFF_VOFF  = 8'h70;
    localparam logic [7:0] OFF_LEVEL = 8'h78;

    // LSB-0 positions of fields given in big-endian numbering
    localparam int B_METHOD    = 63; // be bit 0
    localparam int B_SRC_RST   = 62; // be bit 1
    localparam int B_ESB_VALID = 0;  // be bit 63
    localparam int B_ESB_64K   = 62; // be bit 1
    localparam int B_NT_VALID  = 0;  // be bit 63
    localparam int B_STORE_EOI = 51; // be bit 12
    localparam int B_CHECKED   = 63;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } ntfy_entry_t;
endpackage

// File: rtl/ntfy_regs.sv
module ntfy_regs
    import ntfy_pkg::*;
#(
    parameter int NSRC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       acc_addr,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    input  logic [NSRC-1:0]  src_level,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] esb_o,
    output logic [REG_W-1:0] notif_o,
    output logic [REG_W-1:0] voff_o,
    output logic             src_reset,
    output logic             unsup_pulse,
    output logic             map_on,
    output logic             map_off
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] ictl;
        logic [REG_W-1:0] esb;
        logic [REG_W-1:0] notif;
        logic [REG_W-1:0] voff;
        logic [NSRC-1:0]  level;
        logic [NSRC-1:0]  prev;
        logic             src_rst;
        logic             unsup;
        logic             on;
        logic             off;
    } regs_t;

    regs_t q, d;
    logic aligned, wr_en, chg, method;
    logic [REG_W-1:0] level_word;

    assign aligned = (acc_addr[2:0] == 3'b000);
    assign wr_en   = acc_valid && acc_write && aligned;
    assign method  = q.ictl[B_METHOD];
    assign chg     = (src_level != q.prev);

    always_comb begin
        level_word = '0;
        for (int n = 0; n < NSRC; n++) begin
            level_word[REG_W-1-n] = q.level[n];
        end
    end

    always_comb begin
        d         = q;
        d.src_rst = 1'b0;
        d.on      = 1'b0;
        d.off     = 1'b0;
        d.prev    = src_level;
        d.unsup   = chg && method;
        if (chg && !method) begin
            d.level = src_level;
        end
        if (wr_en) begin
            case (acc_addr)
                OFF_CTRL:  d.ctrl = acc_wdata;
                OFF_ICTL: begin
                    d.ictl    = acc_wdata;
                    d.src_rst = acc_wdata[B_SRC_RST];
                end
                OFF_ESB: begin
                    d.esb = acc_wdata;
                    d.on  = acc_wdata[B_ESB_VALID] && !q.esb[B_ESB_VALID];
                    d.off = !acc_wdata[B_ESB_VALID] && q.esb[B_ESB_VALID];
                end
                OFF_NOTIF: d.notif = acc_wdata;
                OFF_VOFF:  d.voff  = acc_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        acc_rdata = '1;
        if (aligned) begin
            case (acc_addr)
                OFF_CTRL:  acc_rdata = q.ctrl;
                OFF_EMASK: acc_rdata = '0;
                OFF_ICTL:  acc_rdata = q.ictl;
                OFF_ESB:   acc_rdata = q.esb;
                OFF_NOTIF: acc_rdata = q.notif;
                OFF_VOFF:  acc_rdata = q.voff;
                OFF_LEVEL: acc_rdata = level_word;
                default:   acc_rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o      = q.ctrl;
    assign esb_o       = q.esb;
    assign notif_o     = q.notif;
    assign voff_o      = q.voff;
    assign src_reset   = q.src_rst;
    assign unsup_pulse = q.unsup;
    assign map_on      = q.on;
    assign map_off     = q.off;
endmodule

// File: rtl/ntfy_fifo.sv
module ntfy_fifo
    import ntfy_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  ntfy_entry_t push_ent,
    input  logic        pop,
    output ntfy_entry_t head,
    output logic        empty,
    output logic        full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        ntfy_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = q.mem[q.rp];

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wp] = push_ent;
            d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ntfy_issue.sv
module ntfy_issue
    import ntfy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  ntfy_entry_t      q_head,
    output logic             q_pop,
    output logic             st_req,
    output logic [REG_W-1:0] st_addr,
    output logic [REG_W-1:0] st_data,
    input  logic             st_ack,
    input  logic             st_err,
    output logic             store_fail
);
    typedef struct packed {
        logic        busy;
        ntfy_entry_t ent;
        logic        fail;
    } iss_t;

    iss_t q, d;
    logic done;

    assign done  = q.busy && st_ack;
    assign q_pop = !q_empty && (!q.busy || st_ack);

    always_comb begin
        d      = q;
        d.fail = done && st_err;
        if (q_pop) begin
            d.busy = 1'b1;
            d.ent  = q_head;
        end else if (done) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign st_req     = q.busy;
    assign st_addr    = q.ent.addr;
    assign st_data    = q.ent.data;
    assign store_fail = q.fail;
endmodule

// File: rtl/ntfy_trigger_gen.sv
module ntfy_trigger_gen
    import ntfy_pkg::*;
#(
    parameter int NSRC   = 20,
    parameter int QDEPTH = 4,
    parameter int SRC_W  = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       acc_addr,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    input  logic [NSRC-1:0]  src_level,
    input  logic             trig_valid,
    input  logic [SRC_W-1:0] trig_src,
    input  logic             trig_checked,
    output logic             trig_ready,
    output logic             st_req,
    output logic [REG_W-1:0] st_addr,
    output logic [REG_W-1:0] st_data,
    input  logic             st_ack,
    input  logic             st_err,
    output logic             store_fail,
    output logic             unsup_pulse,
    output logic             src_reset,
    output logic             store_eoi,
    output logic             esb_map_en,
    output logic             esb_page64k,
    output logic [REG_W-1:0] esb_base,
    output logic             esb_map_on,
    output logic             esb_map_off
);
    logic [REG_W-1:0] ctrl, esb, notif, voff;
    ntfy_entry_t new_ent, head;
    logic q_empty, q_full, q_pop, push;

    ntfy_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .src_level(src_level),
        .ctrl_o(ctrl), .esb_o(esb), .notif_o(notif), .voff_o(voff),
        .src_reset(src_reset), .unsup_pulse(unsup_pulse),
        .map_on(esb_map_on), .map_off(esb_map_off)
    );

    always_comb begin
        new_ent            = '0;
        new_ent.addr       = notif;
        new_ent.addr[B_NT_VALID] = 1'b0;
        new_ent.data[31:0] = voff[63:32] | {{(32-SRC_W){1'b0}}, trig_src};
        new_ent.data[B_CHECKED] = trig_checked;
    end

    assign trig_ready = !q_full;
    assign push       = trig_valid && !q_full && notif[B_NT_VALID];

    ntfy_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_ent(new_ent),
        .pop(q_pop), .head(head),
        .empty(q_empty), .full(q_full)
    );

    ntfy_issue u_issue (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_head(head), .q_pop(q_pop),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
        .st_ack(st_ack), .st_err(st_err), .store_fail(store_fail)
    );

    assign store_eoi   = ctrl[B_STORE_EOI];
    assign esb_map_en  = esb[B_ESB_VALID];
    assign esb_page64k = esb[B_ESB_64K];
    always_comb begin
        esb_base = esb;
        esb_base[B_ESB_VALID] = 1'b0;
        esb_base[B_ESB_64K]   = 1'b0;
    end
endmodule

// File: rtl/ntfy_trigger_gen_chk.sv
module ntfy_trigger_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_req,
    input logic        st_ack,
    input logic        st_err,
    input logic [63:0] st_addr,
    input logic [63:0] st_data,
    input logic        store_fail,
    input logic        esb_map_on,
    input logic        esb_map_off,
    input logic        esb_map_en
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> st_req); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> $stable(st_addr) && $stable(st_data)); // R9
    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> !st_addr[0]); // R7
    AST_FAIL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        store_fail |-> $past(st_req && st_ack && st_err)); // R10
    AST_MAP_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        esb_map_on |-> esb_map_en); // R11
    AST_MAP_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        esb_map_off |-> !esb_map_en); // R11
    AST_MAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(esb_map_on && esb_map_off)); // R11
endmodule

bind ntfy_trigger_gen ntfy_trigger_gen_chk u_chk (.*);

// File: tb/ntfy_trigger_gen_bench.sv
`timescale 1ns/1ps
module ntfy_trigger_gen_bench;
    localparam int NSRC = 20;
    localparam int SRC_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0;
    logic [7:0] acc_addr = '0;
    logic [63:0] acc_wdata = '0, acc_rdata;
    logic [NSRC-1:0] src_level = '0;
    logic trig_valid = 0, trig_checked = 0, trig_ready;
    logic [SRC_W-1:0] trig_src = '0;
    logic st_req, st_ack = 0, st_err = 0, store_fail;
    logic [63:0] st_addr, st_data, esb_base;
    logic unsup_pulse, src_reset, store_eoi, esb_map_en, esb_page64k, esb_map_on, esb_map_off;

    int total = 0, bad = 0;
    logic [63:0] cap_addr, cap_data;

    always #2.5 clk = ~clk;

    ntfy_trigger_gen u_ntfy_trigger_gen (.*);

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [63:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] CTRL_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VOFF_V = 64'h0000_1000_DEAD_BEEF;
    localparam logic [63:0] NOTIF_V = 64'h0000_0006_0300_0001;

    localparam vec_t VECS [16] = '{
        '{1'b1, 8'h20, CTRL_A, 4'd2},   // R2
        '{1'b0, 8'h20, CTRL_A, 4'd2},   // R2
        '{1'b1, 8'h28, '1, 4'd2},       // R2
        '{1'b0, 8'h28, '0, 4'd2},       // R2
        '{1'b1, 8'h70, VOFF_V, 4'd2},   // R2
        '{1'b0, 8'h70, VOFF_V, 4'd2},   // R2
        '{1'b0, 8'h80, '1, 4'd3},       // R3
        '{1'b0, 8'h24, '1, 4'd3},       // R3
        '{1'b1, 8'h24, 64'h5555_5555_5555_5555, 4'd3}, // R3
        '{1'b0, 8'h20, CTRL_A, 4'd3},   // R3
        '{1'b1, 8'h78, '1, 4'd4},       // R4
        '{1'b0, 8'h78, '0, 4'd4},       // R4
        '{1'b1, 8'h68, NOTIF_V, 4'd2},  // R2
        '{1'b0, 8'h68, NOTIF_V, 4'd2},  // R2
        '{1'b1, 8'h58, 64'h0000_0000_0000_00F0, 4'd2}, // R2
        '{1'b0, 8'h58, 64'h0000_0000_0000_00F0, 4'd2}  // R2
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] v);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = v;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = a;
        #1 v = acc_rdata;
        acc_valid = 0;
    endtask

    task automatic push(input logic [4:0] s, input logic c);
        @(negedge clk);
        trig_valid = 1; trig_src = s; trig_checked = c;
        @(negedge clk);
        trig_valid = 0;
    endtask

    task automatic ack(input logic e, output logic got);
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (st_req) got = 1;
        end
        cap_addr = st_addr; cap_data = st_data;
        st_ack = got; st_err = e;
        @(negedge clk);
        st_ack = 0; st_err = 0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic got;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 st_req", {63'd0, st_req}, 64'd0);
        chk("R1 trig_ready", {63'd0, trig_ready}, 64'd1);
        chk("R1 pins", {58'd0, store_eoi, esb_map_en, src_reset, unsup_pulse, store_fail, esb_map_on}, 64'd0);
        rd(8'h68, v); chk("R1 notif", v, 64'd0);
        rd(8'h60, v); chk("R1 esb", v, 64'd0);

        foreach (VECS[i]) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                chk($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].data);
            end
        end
        wr(8'h58, 64'd0);

        // R12 store-EOI bit
        wr(8'h20, 64'h0008_0000_0000_0000);
        chk("R12 eoi on", {63'd0, store_eoi}, 64'd1);
        wr(8'h20, 64'h0);
        chk("R12 eoi off", {63'd0, store_eoi}, 64'd0);

        // R4 level tracking, big-endian bit order
        @(negedge clk); src_level = 20'h80001;
        @(negedge clk);
        chk("R4 unsup low", {63'd0, unsup_pulse}, 64'd0);
        rd(8'h78, v); chk("R4 level", v, 64'h8000_1000_0000_0000);

        // R5 method bit ignores changes
        wr(8'h58, 64'h8000_0000_0000_0000);
        src_level = 20'h00010;
        @(negedge clk);
        chk("R5 unsup pulse", {63'd0, unsup_pulse}, 64'd1);
        @(negedge clk);
        chk("R5 unsup one cycle", {63'd0, unsup_pulse}, 64'd0);
        rd(8'h78, v); chk("R5 level held", v, 64'h8000_1000_0000_0000);
        wr(8'h58, 64'd0);

        // R6 downstream reset pulse
        wr(8'h58, 64'h4000_0000_0000_0000);
        chk("R6 reset pulse", {63'd0, src_reset}, 64'd1);
        @(negedge clk);
        chk("R6 one cycle", {63'd0, src_reset}, 64'd0);
        wr(8'h58, 64'd0);

        // R7 trigger word and address
        push(5'd5, 1'b1);
        ack(1'b0, got);
        chk("R7 issued", {63'd0, got}, 64'd1);
        chk("R7 addr", cap_addr, 64'h0000_0006_0300_0000);
        chk("R7 data", cap_data, 64'h8000_0000_0000_1005);
        chk("R10 no fail", {63'd0, store_fail}, 64'd0);

        // R10 failed store
        push(5'd2, 1'b0);
        ack(1'b1, got);
        chk("R10 data", cap_data, 64'h0000_0000_0000_1002);
        chk("R10 fail pulse", {63'd0, store_fail}, 64'd1);
        @(negedge clk);
        chk("R10 fail one cycle", {63'd0, store_fail}, 64'd0);

        // R8 invalid notification drops trigger
        wr(8'h68, 64'h0000_0006_0300_0000);
        push(5'd9, 1'b0);
        repeat (6) @(negedge clk);
        chk("R8 no store", {63'd0, st_req}, 64'd0);
        wr(8'h68, NOTIF_V);

        // R9 queue order and full
        for (int s = 1; s <= 5; s++) push(5'(s), 1'b0);
        @(negedge clk);
        chk("R9 full", {63'd0, trig_ready}, 64'd0);
        for (int s = 1; s <= 5; s++) begin
            ack(1'b0, got);
            chk($sformatf("R9 order %0d", s), cap_data, 64'h1000 | 64'(s));
        end
        chk("R9 ready again", {63'd0, trig_ready}, 64'd1);

        // R11 event-buffer base
        wr(8'h60, 64'h4000_0000_1234_0001);
        chk("R11 map_on", {62'd0, esb_map_on, esb_map_off}, 64'd2);
        chk("R11 valid/64k", {62'd0, esb_map_en, esb_page64k}, 64'd3);
        chk("R11 base", esb_base, 64'h0000_0000_1234_0000);
        wr(8'h60, 64'h0000_0000_5678_0001);
        chk("R11 no remap", {62'd0, esb_map_on, esb_map_off}, 64'd0);
        chk("R11 4k", {63'd0, esb_page64k}, 64'd0);
        wr(8'h60, 64'd0);
        chk("R11 map_off", {62'd0, esb_map_on, esb_map_off}, 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule